// File: doc/BRIEF.md
# Watchdog and Reset Timing Sequencer

This block turns a digitized supply-low flag, a watchdog activity input and a slow timebase into a processor reset and a watchdog fault flag. When the supply recovers, reset stays asserted for a fixed number of timebase ticks. After that the block watches the activity input. If that input stops changing for longer than the watchdog period, the block raises the fault flag and issues a reset pulse of the same fixed length. The first watch period after every reset release uses a longer limit, which gives the processor time to boot.

Timing is counted in ticks of a clock enable (`tick`). Two mode inputs pick the period set. With `ext_timebase` high, the ticks come from an external clock and the periods are fixed cycle counts. With it low, the ticks come from an internal oscillator, and `short_wd` chooses between a long normal period and a short one. Every count is a parameter, so simulation can run with small values.

A controller state machine has five states:
- `ST_HOLD`: the supply is low.
- `ST_DELAY`: the reset timeout is running.
- `ST_FIRST`: the first, long watch period.
- `ST_WATCH`: the normal watch period.
- `ST_PARKED`: the watchdog input is floating.

The transitions are:
- Any state goes to `ST_HOLD` when `supply_low` is high.
- `ST_HOLD` goes to `ST_DELAY` when the supply recovers.
- `ST_DELAY` goes to `ST_FIRST` when the reset count expires.
- `ST_FIRST` or `ST_WATCH` goes to `ST_WATCH` on activity.
- `ST_FIRST` or `ST_WATCH` goes to `ST_DELAY` on a timeout.
- `ST_FIRST` or `ST_WATCH` goes to `ST_PARKED` when the input floats.
- `ST_PARKED` goes to `ST_WATCH` when the input stops floating.

Both reset outputs are decoded from the registered state.

Top module: `wdt_rst_seq`

## Requirements
- R1: `rst_out` is 1 and `rst_out_n` is 0 in the cycle after `supply_low` is sampled high, and they stay that way while it stays high. During and after the asynchronous `rst_n`, the block is held in reset (`ST_HOLD`).
- R2: After `supply_low` is sampled low, reset deasserts in the cycle following the Nth `tick`, where N is the reset timeout.
- R3: With `ext_timebase`=1, the limits are as follows (defaults in brackets):
  - reset timeout: `EXT_RST_TICKS` [2048]
  - normal watch period: `EXT_WD_TICKS` [1024]
  - first watch period after release: `EXT_FIRST_TICKS` [4096]
- R4: With `ext_timebase`=0, the reset timeout is `INT_RST_TICKS` and the first period is `INT_LONG_TICKS`. The normal period is `INT_LONG_TICKS` when `short_wd`=0 and `INT_SHORT_TICKS` when `short_wd`=1.
- R5: Activity restarts the watch count from zero and moves the block to the normal period. Activity is any rising or falling edge of `wd_in`, taken after a `SYNC_STAGES`-flop synchronizer. A pulse two or more clocks wide counts as activity. An edge in the same cycle as the final tick wins over the timeout.
- R6: When a watch count reaches its limit, `wd_fault_n` goes 0 and reset asserts at the same clock edge. Reset then lasts one reset timeout and is followed by a first (long) watch period.
- R7: `wd_fault_n` stays 0 through the reset pulse and afterwards, until the next edge on `wd_in`. That edge sets it back to 1.
- R8: With `wd_in` static, reset repeats. Each reset pulse of one reset timeout is followed by one first-period watch interval, indefinitely.
- R9: While `wd_float`=1, `wd_fault_n` is 1 from the next cycle and no watchdog reset occurs. When `wd_float` clears, a normal period starts counting from zero.
- R10: While `supply_low`=1, the watchdog does not count and `wd_fault_n` is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase clock enable, one cycle per timebase period |
| supply_low | input | 1 | Digitized supply-below-threshold flag |
| wd_in | input | 1 | Watchdog activity input (asynchronous) |
| wd_float | input | 1 | Watchdog input detected as unconnected |
| ext_timebase | input | 1 | 1: external-clock period set; 0: internal-oscillator set |
| short_wd | input | 1 | Internal set only: 1 selects the short normal period |
| rst_out | output | 1 | Processor reset, active high |
| rst_out_n | output | 1 | Processor reset, active low |
| wd_fault_n | output | 1 | Watchdog fault flag, active low |

## Verification
The bench sweeps all four mode combinations and measures each period by counting ticks until an output changes. A wrong limit or an off-by-one in the counter therefore shows up as a tick count that differs from the arithmetic expectation.

The bench also targets three orderings:
- The fault flag must survive the reset pulse and clear only on a later edge. A design that cleared it on reset release would report activity that never happened.
- After a timeout, the long first period must come back. A design that resumed with the normal period would produce reset pulses at the wrong rate.
- A two-clock pulse and a restart just before expiry must both push the timeout out by a full normal period.

Finally, the bench checks that floating and low-supply conditions force the fault flag high even when it was already low, and that a normal count starts from zero once floating ends.

// File: rtl/wdt_rst_pkg.sv
package wdt_rst_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_DELAY  = 3'd1,
        ST_FIRST  = 3'd2,
        ST_WATCH  = 3'd3,
        ST_PARKED = 3'd4
    } seq_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign edge_o = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
    parameter int EXT_RST_TICKS   = 2048,
    parameter int EXT_WD_TICKS    = 1024,
    parameter int EXT_FIRST_TICKS = 4096,
    parameter int INT_RST_TICKS   = 200,
    parameter int INT_LONG_TICKS  = 1600,
    parameter int INT_SHORT_TICKS = 100,
    parameter int CW              = 13
) (
    input  logic          ext_timebase,
    input  logic          short_wd,
    output logic [CW-1:0] rst_lim,
    output logic [CW-1:0] first_lim,
    output logic [CW-1:0] norm_lim
);
    always_comb begin
        if (ext_timebase) begin
            rst_lim   = CW'(EXT_RST_TICKS);
            first_lim = CW'(EXT_FIRST_TICKS);
            norm_lim  = CW'(EXT_WD_TICKS);
        end else begin
            rst_lim   = CW'(INT_RST_TICKS);
            first_lim = CW'(INT_LONG_TICKS);
            norm_lim  = short_wd ? CW'(INT_SHORT_TICKS) : CW'(INT_LONG_TICKS);
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    // a tick that lands on the last count ends the period
    assign done = en && (cnt >= limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (done) cnt <= '0;
        else if (en)   cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq
    import wdt_rst_pkg::*;
#(
    parameter int EXT_RST_TICKS   = 2048,
    parameter int EXT_WD_TICKS    = 1024,
    parameter int EXT_FIRST_TICKS = 4096,
    parameter int INT_RST_TICKS   = 200,
    parameter int INT_LONG_TICKS  = 1600,
    parameter int INT_SHORT_TICKS = 100,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_low,
    input  logic wd_in,
    input  logic wd_float,
    input  logic ext_timebase,
    input  logic short_wd,
    output logic rst_out,
    output logic rst_out_n,
    output logic wd_fault_n
);
    localparam int MAXL = max_of(max_of(EXT_RST_TICKS, EXT_WD_TICKS),
                                 max_of(max_of(EXT_FIRST_TICKS, INT_RST_TICKS),
                                        max_of(INT_LONG_TICKS, INT_SHORT_TICKS)));
    localparam int CW = $clog2(MAXL + 1);

    seq_state_e    state_q, state_d;
    logic          wd_edge;
    logic          timeout;
    logic          cnt_clr, cnt_en, cnt_done;
    logic [CW-1:0] rst_lim, first_lim, norm_lim, cur_lim;

    wdt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(wd_in), .edge_o(wd_edge)
    );

    wdt_period_sel #(
        .EXT_RST_TICKS(EXT_RST_TICKS), .EXT_WD_TICKS(EXT_WD_TICKS),
        .EXT_FIRST_TICKS(EXT_FIRST_TICKS), .INT_RST_TICKS(INT_RST_TICKS),
        .INT_LONG_TICKS(INT_LONG_TICKS), .INT_SHORT_TICKS(INT_SHORT_TICKS),
        .CW(CW)
    ) sel_i (
        .ext_timebase(ext_timebase), .short_wd(short_wd),
        .rst_lim(rst_lim), .first_lim(first_lim), .norm_lim(norm_lim)
    );

    wdt_tick_counter #(.CW(CW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
        .limit(cur_lim), .done(cnt_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        timeout = 1'b0;
        if (supply_low) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = ST_DELAY;
                ST_DELAY: if (cnt_done) state_d = ST_FIRST;
                ST_FIRST, ST_WATCH: begin
                    if (wd_float) begin
                        state_d = ST_PARKED;
                    end else if (wd_edge) begin
                        state_d = ST_WATCH;
                    end else if (cnt_done) begin
                        state_d = ST_DELAY;
                        timeout = 1'b1;
                    end
                end
                ST_PARKED: if (!wd_float) state_d = ST_WATCH;
                default:   state_d = ST_HOLD;
            endcase
        end
    end

    // counter control
    always_comb begin
        cnt_en  = tick && (state_q == ST_DELAY || state_q == ST_FIRST ||
                           state_q == ST_WATCH);
        cnt_clr = (state_d != state_q) || (state_q == ST_HOLD) ||
                  (state_q == ST_PARKED) || (state_q == ST_WATCH && wd_edge);
        unique case (state_q)
            ST_DELAY: cur_lim = rst_lim;
            ST_FIRST: cur_lim = first_lim;
            default:  cur_lim = norm_lim;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // fault flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      wd_fault_n <= 1'b1;
        else if (supply_low || wd_float) wd_fault_n <= 1'b1;
        else if (timeout)                wd_fault_n <= 1'b0;
        else if (wd_edge)                wd_fault_n <= 1'b1;
    end

    // outputs decoded from the registered state
    always_comb begin
        rst_out   = (state_q == ST_HOLD) || (state_q == ST_DELAY);
        rst_out_n = !rst_out;
    end

    // R1
    supply_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_out);

    // R2
    release_after_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> !$past(supply_low));

    // R6
    fault_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_fault_n) |-> rst_out);

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_fault_n && !wd_edge && !wd_float && !supply_low) |=> !wd_fault_n);

    // R9
    float_clears_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_float |=> wd_fault_n);

    // R10
    low_supply_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> wd_fault_n);

endmodule

// File: tb/wdt_rst_seq_tb_top.sv
module wdt_rst_seq_tb_top;

    localparam int P_EXT_RST   = 8;
    localparam int P_EXT_WD    = 6;
    localparam int P_EXT_FIRST = 12;
    localparam int P_INT_RST   = 5;
    localparam int P_INT_LONG  = 10;
    localparam int P_INT_SHORT = 3;
    localparam int MAXN        = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_low = 1'b1;
    logic wd_in = 1'b0;
    logic wd_float = 1'b0;
    logic ext_timebase = 1'b0;
    logic short_wd = 1'b0;
    logic rst_out, rst_out_n, wd_fault_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    wdt_rst_seq #(
        .EXT_RST_TICKS(P_EXT_RST), .EXT_WD_TICKS(P_EXT_WD),
        .EXT_FIRST_TICKS(P_EXT_FIRST), .INT_RST_TICKS(P_INT_RST),
        .INT_LONG_TICKS(P_INT_LONG), .INT_SHORT_TICKS(P_INT_SHORT),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low),
        .wd_in(wd_in), .wd_float(wd_float), .ext_timebase(ext_timebase),
        .short_wd(short_wd), .rst_out(rst_out), .rst_out_n(rst_out_n),
        .wd_fault_n(wd_fault_n)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    // sel 0: rst_out, 1: wd_fault_n
    task automatic ticks_until(input int sel, input logic val, output int n);
        n = -1;
        for (int k = 1; k <= MAXN; k++) begin
            one_tick();
            if ((sel == 0 ? rst_out : wd_fault_n) == val) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic toggle_wd();
        @(negedge clk) wd_in = ~wd_in;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n, e_rst, e_first, e_norm;
        repeat (4) @(negedge clk);
        check("R1 reset state rst_out", int'(rst_out), 1);
        check("R1 reset state rst_out_n", int'(rst_out_n), 0);
        check("R10 reset state fault", int'(wd_fault_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int m = 0; m < 4; m++) begin
            ext_timebase = m[1];
            short_wd     = m[0];
            e_rst   = m[1] ? P_EXT_RST : P_INT_RST;
            e_first = m[1] ? P_EXT_FIRST : P_INT_LONG;
            e_norm  = m[1] ? P_EXT_WD : (m[0] ? P_INT_SHORT : P_INT_LONG);

            supply_low = 1'b1;
            repeat (3) @(negedge clk);
            check("R1 supply low rst_out", int'(rst_out), 1);
            check("R10 supply low fault high", int'(wd_fault_n), 1);
            repeat (2) one_tick();
            check("R1 held while low", int'(rst_out_n), 0);

            supply_low = 1'b0;
            ticks_until(0, 1'b0, n);
            check("R2 R3 R4 reset timeout", n, e_rst);

            ticks_until(1, 1'b0, n);
            check("R3 R4 first period", n, e_first);
            check("R6 reset with fault", int'(rst_out), 1);
            ticks_until(0, 1'b0, n);
            check("R6 fault pulse length", n, e_rst);
            check("R7 fault held after pulse", int'(wd_fault_n), 0);

            ticks_until(0, 1'b1, n);
            check("R8 repeat uses first period", n, e_first);
            ticks_until(0, 1'b0, n);
            check("R8 repeat pulse length", n, e_rst);

            wd_float = 1'b1;
            repeat (2) @(negedge clk);
            check("R9 float forces fault high", int'(wd_fault_n), 1);
            repeat (MAXN) one_tick();
            check("R9 no reset while floating", int'(rst_out), 0);
            wd_float = 1'b0;
            ticks_until(0, 1'b1, n);
            check("R9 normal period after float", n, e_norm);
            ticks_until(0, 1'b0, n);
            check("R6 pulse after float", n, e_rst);

            toggle_wd();
            check("R7 edge restores fault", int'(wd_fault_n), 1);
            repeat (e_norm - 1) one_tick();
            check("R5 no timeout before limit", int'(rst_out), 0);
            toggle_wd();
            repeat (e_norm - 1) one_tick();
            check("R5 restart pushes timeout", int'(rst_out), 0);

            @(negedge clk) wd_in = ~wd_in;
            @(negedge clk);
            @(negedge clk) wd_in = ~wd_in;
            repeat (4) @(negedge clk);
            ticks_until(0, 1'b1, n);
            check("R5 short pulse restarts normal period", n, e_norm);
            check("R6 fault low on timeout", int'(wd_fault_n), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule